// File: doc/BRIEF.md
# Cascaded Three-Digit Decimal Counter

This block is a free-running decimal counter made of three 4-bit BCD digit stages: units, tens and hundreds. It has no data or enable input. Every rising clock edge moves the count one step through 000, 001, ..., 999, after which it wraps back to 000.

Each digit drives a terminal-count flag. The flag is high for exactly the one cycle in which its digit holds nine. A digit moves only when every less significant digit is at its terminal count, so the chain stays fully synchronous on a single clock. A separate wrap flag marks the single cycle in which the whole count reads 999.

A control module turns the terminal-count flags into per-digit advance strobes. A datapath module holds the digit registers. A thin top joins the two. Software takes the digits, the flags and the wrap pulse straight from the ports.

Top module: `bcdc_top`

## Requirements
- R1: Each digit output is a 4-bit binary code and only ever shows 0000 to 1001 (0 to 9).
- R2: The units digit advances by one on every clock edge while reset is low, and goes from 9 to 0.
- R3: The tens digit changes only on an edge where the units terminal count is high. It then advances by one, going from 9 to 0.
- R4: The hundreds digit changes only on an edge where the units and tens terminal counts are both high. It then advances by one, going from 9 to 0.
- R5: Bit i of `digitTc` is 1 exactly while digit i holds 9 and is 0 otherwise. Bit 0 is units, bit 1 is tens and bit 2 is hundreds.
- R6: `wrapFlag` is 1 exactly in the cycle in which the count is 999, and the next edge brings the count to 000.
- R7: Synchronous active-high reset: an edge with `rst` high sets all three digits to 0 and clears every flag.
- R8: After reset is released, the count after k clock edges equals k mod 1000, read as hundreds*100 + tens*10 + units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every rising edge is one count step |
| rst | input | 1 | Synchronous active-high reset |
| onesBcd | output | 4 | Units digit |
| tensBcd | output | 4 | Tens digit |
| hundredsBcd | output | 4 | Hundreds digit |
| digitTc | output | 3 | Per-digit terminal count; bit 0 units, bit 1 tens, bit 2 hundreds |
| wrapFlag | output | 1 | High in the cycle the count reads 999 |

## Verification
Every digit is a single register stage, so a count step is visible one edge after the edge that causes it. The terminal-count and wrap flags are combinational on the digits and are valid in the same cycle as the digit they describe. Reset takes effect at the first edge where it is sampled high, and the first step after release shows up one edge later. The bench drives `rst` and samples every output on the falling clock edge. At each sample it compares against the k mod 1000 value it has computed, for k edges since release. This sweep runs across more than two full wraps and includes a reset applied in mid-run.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;

  // Stage geometry of the decimal chain.
  parameter int unsigned DIGIT_W    = 4;
  parameter int unsigned NUM_DIGITS = 3;
  parameter int unsigned DIGIT_MAX  = 9;

  localparam int unsigned COUNT_W = DIGIT_W * NUM_DIGITS;

  typedef logic [DIGIT_W-1:0] digit_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                  clear;
    logic [NUM_DIGITS-1:0] advance;
  } strobe_t;

endpackage

// File: rtl/bcdc_digit.sv
module bcdc_digit #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned MAXV  = 9
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             advance,
  output logic [WIDTH-1:0] value,
  output logic             termCount
);

  localparam logic [WIDTH-1:0] LAST = WIDTH'(MAXV);

  logic [WIDTH-1:0] valueQ;
  logic [WIDTH-1:0] valueD;

  // Any code at or above the last legal value rolls to zero, so an
  // illegal code self-clears on its next advance.
  always_comb begin
    valueD = valueQ;
    if (clear) begin
      valueD = '0;
    end else if (advance) begin
      if (valueQ >= LAST) valueD = '0;
      else                valueD = valueQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    valueQ <= valueD;
  end

  assign value     = valueQ;
  assign termCount = (valueQ == LAST);

endmodule

// File: rtl/bcdc_datapath.sv
module bcdc_datapath
  import bcdc_pkg::*;
(
  input  logic                  clk,
  input  strobe_t               strobe,
  output logic [COUNT_W-1:0]    countVec,
  output logic [NUM_DIGITS-1:0] tcVec
);

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_stage
    bcdc_digit #(
      .WIDTH(DIGIT_W),
      .MAXV (DIGIT_MAX)
    ) u_digit (
      .clk      (clk),
      .clear    (strobe.clear),
      .advance  (strobe.advance[i]),
      .value    (countVec[i*DIGIT_W +: DIGIT_W]),
      .termCount(tcVec[i])
    );
  end

endmodule

// File: rtl/bcdc_ctrl.sv
module bcdc_ctrl
  import bcdc_pkg::*;
(
  input  logic                  rst,
  input  logic [NUM_DIGITS-1:0] tcVec,
  output strobe_t               strobe,
  output logic                  wrapAll
);

  // Carry chain: stage i advances when every lower stage is at terminal count.
  logic [NUM_DIGITS:0] carry;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_carry
    assign carry[i+1]        = carry[i] & tcVec[i];
    assign strobe.advance[i] = carry[i];
  end

  assign strobe.clear = rst;
  assign wrapAll      = carry[NUM_DIGITS];

endmodule

// File: rtl/bcdc_top.sv
module bcdc_top
  import bcdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output logic [3:0] onesBcd,
  output logic [3:0] tensBcd,
  output logic [3:0] hundredsBcd,
  output logic [2:0] digitTc,
  output logic       wrapFlag
);

  strobe_t               strobe;
  logic [COUNT_W-1:0]    countVec;
  logic [NUM_DIGITS-1:0] tcVec;
  logic                  wrapAll;

  bcdc_ctrl u_ctrl (
    .rst    (rst),
    .tcVec  (tcVec),
    .strobe (strobe),
    .wrapAll(wrapAll)
  );

  bcdc_datapath u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .countVec(countVec),
    .tcVec   (tcVec)
  );

  assign onesBcd     = countVec[0*DIGIT_W +: 4];
  assign tensBcd     = countVec[1*DIGIT_W +: 4];
  assign hundredsBcd = countVec[2*DIGIT_W +: 4];
  assign digitTc     = tcVec[2:0];
  assign wrapFlag    = wrapAll;

endmodule

// File: rtl/bcdc_checker.sv
module bcdc_checker (
  input logic       clk,
  input logic       rst,
  input logic [3:0] onesBcd,
  input logic [3:0] tensBcd,
  input logic [3:0] hundredsBcd,
  input logic [2:0] digitTc,
  input logic       wrapFlag
);

  a_r1_legal_digits: assert property (@(posedge clk) disable iff (rst)
    (onesBcd <= 4'd9) && (tensBcd <= 4'd9) && (hundredsBcd <= 4'd9));

  a_r2_units_step: assert property (@(posedge clk) disable iff (rst)
    (onesBcd != 4'd9) |=> (onesBcd == $past(onesBcd) + 4'd1));

  a_r2_units_wrap: assert property (@(posedge clk) disable iff (rst)
    (onesBcd == 4'd9) |=> (onesBcd == 4'd0));

  a_r3_tens_hold: assert property (@(posedge clk) disable iff (rst)
    !digitTc[0] |=> $stable(tensBcd));

  a_r4_hundreds_hold: assert property (@(posedge clk) disable iff (rst)
    !(digitTc[0] && digitTc[1]) |=> $stable(hundredsBcd));

  a_r5_tc_after_eight: assert property (@(posedge clk) disable iff (rst)
    $rose(digitTc[0]) |-> ($past(onesBcd) == 4'd8));

  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    wrapFlag |=> (onesBcd == 4'd0 && tensBcd == 4'd0 && hundredsBcd == 4'd0));

  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (onesBcd == 4'd0 && tensBcd == 4'd0 && hundredsBcd == 4'd0
             && digitTc == 3'b000 && !wrapFlag));

endmodule

bind bcdc_top bcdc_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .onesBcd    (onesBcd),
  .tensBcd    (tensBcd),
  .hundredsBcd(hundredsBcd),
  .digitTc    (digitTc),
  .wrapFlag   (wrapFlag)
);

// File: tb/sim_bcdc_top.sv
module sim_bcdc_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] onesBcd, tensBcd, hundredsBcd;
  logic [2:0] digitTc;
  logic       wrapFlag;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  bcdc_top u0 (
    .clk        (clk),
    .rst        (rst),
    .onesBcd    (onesBcd),
    .tensBcd    (tensBcd),
    .hundredsBcd(hundredsBcd),
    .digitTc    (digitTc),
    .wrapFlag   (wrapFlag)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  // Compare every output against count value k mod 1000.
  task automatic checkCount(input int k);
    int v  = k % 1000;
    int u  = v % 10;
    int t  = (v / 10) % 10;
    int h  = v / 100;
    int tc = ((h == 9) << 2) | ((t == 9) << 1) | (u == 9);
    check("R2 units", onesBcd, u);
    check("R3 tens", tensBcd, t);
    check("R4 hundreds", hundredsBcd, h);
    check("R5 digitTc", digitTc, tc);
    check("R6 wrapFlag", wrapFlag, (v == 999));
    check("R8 count", hundredsBcd * 100 + tensBcd * 10 + onesBcd, v);
    check("R1 legal", (onesBcd <= 9) && (tensBcd <= 9) && (hundredsBcd <= 9), 1);
  endtask

  task automatic checkZero(input string req);
    check(req, {hundredsBcd, tensBcd, onesBcd}, 0);
    check(req, {digitTc, wrapFlag}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkZero("R7 reset");
    rst = 1'b0;
    for (int k = 1; k <= 2105; k++) begin
      @(negedge clk);
      checkCount(k);
    end
    // Mid-run reset.
    rst = 1'b1;
    @(negedge clk);
    checkZero("R7 midrun reset");
    @(negedge clk);
    checkZero("R7 held reset");
    rst = 1'b0;
    for (int k = 1; k <= 25; k++) begin
      @(negedge clk);
      checkCount(k);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule